// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block drives a parallel port whose pins have no direction register. Each pin holds one output latch bit, and that bit alone decides how the pin behaves. A latch bit of 0 turns on a strong sink, so the pin is held low. A latch bit of 1 leaves only a weak source to the supply active. The pin then reads high, but any external device can pull it low, so the pin works as an input.

When a write takes a latch bit from 0 to 1, the pin also gets a strong pull-up to give it a fast rising edge. This pull-up lasts only until the next falling edge of the serial bus clock, which the surrounding bus interface reports as a one-cycle strobe. The value read back from each pin is the resolved pad level, carried through a synchroniser chain. A pin whose latch is 0 is held low by its own sink, so it reads 0.

Top module: `qbp_port_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, every latch bit is 1 and every pin has only its weak source enabled (`sink_en`=0, `kick_en`=0, `hold_en`=1). Every `rd_val` bit is 1 and stays 1 until new pad samples reach the end of the synchroniser.
- R2: A cycle with `wr_stb`=1 loads `wr_data` into the latch. From the next cycle, every pin with latch bit 0 has `sink_en`=1, `kick_en`=0 and `hold_en`=0.
- R3: From the cycle after the write, every pin with latch bit 1 has `sink_en`=0 and `hold_en`=1. For every pin, exactly one of `sink_en` and `hold_en` is set.
- R4: A write that takes a pin's latch bit from 0 to 1 sets `kick_en` for that pin from the next cycle. `kick_en` is never 1 on a pin whose latch bit is 0.
- R5: A cycle with `scl_fall`=1 and no write clears every `kick_en` bit from the next cycle. Without such a strobe, `kick_en` holds its value, except where a write loads a 0.
- R6: A write of 1 to a pin whose latch is already 1 does not start a new `kick_en` pulse, and it does not clear a pulse still running on that pin.
- R7: When `wr_stb` and `scl_fall` arrive in the same cycle, the strobe clears the running pulses first. Pins that the write takes from 0 to 1 then get a new pulse.
- R8: `rd_val` equals `pad_in` as it was SYNC_STAGES clock edges earlier, and it is reset to all ones.
- R9: A pin with latch bit 0 sits low on the pad, so a later `rd_val` for that pin is 0 whatever the external device does. A pin with latch bit 1 reads 0 only while an external device pulls it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Latch write strobe |
| wr_data | input | PINS | New latch value |
| scl_fall | input | 1 | One-cycle strobe for a serial clock falling edge |
| pad_in | input | PINS | Resolved pad level of each pin |
| sink_en | output | PINS | Strong pull-low enable |
| kick_en | output | PINS | Brief strong pull-up enable |
| hold_en | output | PINS | Weak pull-up enable |
| rd_val | output | PINS | Synchronised pad read-back |

## Verification
The bench builds the block with PINS=8 and SYNC_STAGES=2. With these values all 256 latch patterns can be written in turn, so every pin sees every mix of neighbour states, and each walk covers 0-to-1, 1-to-1 and 1-to-0 transitions. With only two stages, the read-back path is short enough that a pad change lands at a known edge in every directed case. An external pull-low on held pins and on sinking pins is applied in turn. Coincident write and clock-fall strobes are applied at the same time.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

    typedef enum logic [1:0] {
        PIN_SINK = 2'd0,
        PIN_KICK = 2'd1,
        PIN_HOLD = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic sink;
        logic kick;
        logic hold;
    } pin_en_t;

    function automatic pin_mode_e mode_of(input logic lat, input logic kick);
        if (!lat)
            return PIN_SINK;
        else if (kick)
            return PIN_KICK;
        else
            return PIN_HOLD;
    endfunction

    function automatic pin_en_t enables_of(input pin_mode_e m);
        pin_en_t e;
        case (m)
            PIN_SINK: e = '{sink: 1'b1, kick: 1'b0, hold: 1'b0};
            PIN_KICK: e = '{sink: 1'b0, kick: 1'b1, hold: 1'b1};
            PIN_HOLD: e = '{sink: 1'b0, kick: 1'b0, hold: 1'b1};
            default:  e = '{sink: 1'b1, kick: 1'b0, hold: 1'b0};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/qbp_latch.sv
module qbp_latch #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_stb,
    input  logic [PINS-1:0] wr_data,
    output logic [PINS-1:0] latch_q,
    output logic [PINS-1:0] fresh
);
    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '1;
        else if (wr_stb)
            latch_q <= wr_data;
    end

    // pins this write lifts from low to high
    always_comb fresh = wr_stb ? (wr_data & ~latch_q) : '0;

    assert_latch_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> latch_q == $past(wr_data));

    assert_latch_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(latch_q));
endmodule

// File: rtl/qbp_kick.sv
module qbp_kick #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_stb,
    input  logic [PINS-1:0] wr_data,
    input  logic [PINS-1:0] fresh,
    input  logic            scl_fall,
    input  logic [PINS-1:0] latch_q,
    output logic [PINS-1:0] kick_q
);
    logic [PINS-1:0] keep;
    logic [PINS-1:0] kick_d;

    always_comb begin
        keep = scl_fall ? '0 : kick_q;
        if (wr_stb)
            keep = keep & wr_data;
        kick_d = keep | fresh;
    end

    always_ff @(posedge clk) begin
        if (rst)
            kick_q <= '0;
        else
            kick_q <= kick_d;
    end

    assert_kick_only_high_R4: assert property (@(posedge clk) disable iff (rst)
        (kick_q & ~latch_q) == '0);

    assert_kick_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (scl_fall && !wr_stb) |=> kick_q == '0);

    assert_no_repulse_R6: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> (kick_q & ~$past(kick_q) & $past(latch_q)) == '0);
endmodule

// File: rtl/qbp_sync.sv
module qbp_sync #(
    parameter int PINS   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] d,
    output logic [PINS-1:0] q
);
    logic [STAGES-1:0][PINS-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '1;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '1;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qbp_port_ctrl.sv
module qbp_port_ctrl #(
    parameter int PINS        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_stb,
    input  logic [PINS-1:0] wr_data,
    input  logic            scl_fall,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] sink_en,
    output logic [PINS-1:0] kick_en,
    output logic [PINS-1:0] hold_en,
    output logic [PINS-1:0] rd_val
);
    import qbp_pkg::*;

    logic [PINS-1:0] latch_q;
    logic [PINS-1:0] fresh;
    logic [PINS-1:0] kick_q;

    qbp_latch #(.PINS(PINS)) u_latch (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .latch_q(latch_q), .fresh(fresh)
    );

    qbp_kick #(.PINS(PINS)) u_kick (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .fresh(fresh), .scl_fall(scl_fall), .latch_q(latch_q), .kick_q(kick_q)
    );

    qbp_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(rd_val)
    );

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pin_en_t en;
        always_comb en = enables_of(mode_of(latch_q[p], kick_q[p]));
        assign sink_en[p] = en.sink;
        assign kick_en[p] = en.kick;
        assign hold_en[p] = en.hold;

        assert_one_drive_R3: assert property (@(posedge clk) disable iff (rst)
            $countones({sink_en[p], hold_en[p]}) == 1);

        assert_kick_needs_hold_R4: assert property (@(posedge clk) disable iff (rst)
            kick_en[p] |-> hold_en[p]);
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (sink_en == '0 && kick_en == '0 && hold_en == '1));
endmodule

// File: tb/tb_qbp_port_ctrl.sv
module tb_qbp_port_ctrl;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_stb = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         scl_fall = 1'b0;
    logic [W-1:0] ext_low = '0;
    logic [W-1:0] pad_in;
    logic [W-1:0] sink_en, kick_en, hold_en, rd_val;

    always #4 clk = ~clk;

    // pad resolver: own sink or external pull wins over any pull-up
    assign pad_in = ~sink_en & ~ext_low;

    qbp_port_ctrl #(.PINS(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .scl_fall(scl_fall), .pad_in(pad_in), .sink_en(sink_en),
        .kick_en(kick_en), .hold_en(hold_en), .rd_val(rd_val)
    );

    // behavioural reference
    logic [W-1:0] m_lat = '1;
    logic [W-1:0] m_kick = '0;
    logic [W-1:0] m_sync[$] = '{8'hFF, 8'hFF};
    int           total = 0;
    int           bad = 0;
    string        tag = "R1";
    bit           done = 0;

    always @(posedge clk) begin
        logic [W-1:0] pad_now;
        logic [W-1:0] nk;
        pad_now = 0;
        for (int i = 0; i < W; i++)
            pad_now[i] = m_lat[i] ? ~ext_low[i] : 1'b0;
        if (rst) begin
            m_lat = '1;
            m_kick = '0;
            m_sync = '{8'hFF, 8'hFF};
        end else begin
            void'(m_sync.pop_front());
            m_sync.push_back(pad_now);
            nk = m_kick;
            for (int i = 0; i < W; i++) begin
                if (scl_fall) nk[i] = 1'b0;
                if (wr_stb) begin
                    if (!wr_data[i]) nk[i] = 1'b0;
                    else if (!m_lat[i]) nk[i] = 1'b1;
                end
            end
            m_kick = nk;
            if (wr_stb) m_lat = wr_data;
        end
    end

    task automatic cmp(string what, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            cmp("sink_en", sink_en, ~m_lat);
            cmp("hold_en", hold_en, m_lat);
            cmp("kick_en", kick_en, m_kick);
            cmp("rd_val",  rd_val,  m_sync[0]);
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [W-1:0] v, logic fall = 1'b0);
        wr_data = v; wr_stb = 1'b1; scl_fall = fall;
        tick();
        wr_stb = 1'b0; scl_fall = 1'b0;
    endtask

    task automatic fall();
        scl_fall = 1'b1;
        tick();
        scl_fall = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tag = "R1";
        tick(3);
        tag = "R2";  wr(8'h00); tick(3);
        tag = "R4";  wr(8'hA5); tick(2);
        tag = "R5";  fall(); tick(2);
        tag = "R6";  wr(8'hF0); tick(1); wr(8'hF5); tick(2);
        tag = "R6_hold"; wr(8'hFF); tick(2); fall();
        tag = "R7";  wr(8'h00); wr(8'h3C, 1'b1); tick(2); wr(8'hFF, 1'b1); tick(2);
        tag = "R9";  ext_low = 8'h0F; tick(4); wr(8'h33); tick(4);
        ext_low = 8'hFF; tick(4); ext_low = 8'h00; tick(4);
        tag = "R8";  wr(8'hFF); fall();
        for (int k = 0; k < 16; k++) begin
            ext_low = W'(k * 37); tick(1);
        end
        ext_low = '0; tick(3);
        tag = "R3";
        for (int v = 0; v < 256; v++) begin
            wr(W'(v));
            if (v % 3 == 0) fall();
            if (v % 5 == 0) ext_low = W'(v ^ 8'h5A);
        end
        ext_low = '0; tick(4);
        tag = "R1_mid"; rst = 1'b1; tick(2); rst = 1'b0; tick(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule